// File: doc/BRIEF.md
# Two-Rail Serial Word Receiver

This block takes one avionics serial data line after it has already been turned into two logic rails: one rail that is high during a one, and one rail that is high during a zero. When both rails are low, the line is null. The block samples the rails ten times per nominal bit. The sample rate comes from the core clock divided by one of two ratios. It recovers bits from the return-to-null waveform and counts them into a 32-bit word. Any word that breaks the one/null/zero pattern is thrown away.

A complete word can be filtered on its ninth and tenth bits. Its last bit is replaced by the result of a parity check. The word is then held in a latch and announced by an active-low ready flag. A host reads the word as two 16-bit halves: it chooses the half with a select input and pulses an active-low read strobe. The ready flag clears once both halves have been read, in either order. A newer accepted word replaces a latched word that has not yet been read.

Top module: `a429_word_rx`

## Requirements
- R1: The sample tick runs at the core clock divided by 10 when `slowRate` is 0 and by 80 when it is 1. A bit lasts ten ticks, and words are received correctly at either rate.
- R2: A bit is recognised when one rail has been high for 3 to 7 consecutive ticks and is followed by a null tick. The first bit received is word bit 1.
- R3: An error ends the current word and discards it. The errors are: both rails high at once, a change from one rail directly to the other, a run shorter than 3 ticks, and a run longer than 7 ticks. After an error the receiver waits for a word gap.
- R4: A null lasting at least 25 consecutive ticks is a word gap. It clears the bit count, discards any partial word and arms the receiver for a new word.
- R5: After 32 bits the word is accepted if `matchEn` is 0. It is also accepted if word bit 9 equals `matchBits[0]` and word bit 10 equals `matchBits[1]`. Otherwise the word is dropped, and both the latch and the flag are left unchanged.
- R6: In the latched word, bit 32 is 0 when the 32 received bits hold an odd number of ones, and 1 when they hold an even number.
- R7: With `halfSel`=0 the bus carries the following: bits 15..11 hold word bits 13..9; bit 10 holds word bit 31; bit 9 holds word bit 30; bit 8 holds the parity result; bits 7..0 hold word bits 1..8.
- R8: With `halfSel`=1, bus bits 15..0 carry word bits 29 down to 14.
- R9: `readyN` is 1 after reset and falls when a word is accepted. It rises only after both halves have been read while it is low, in either order. Reading the same half twice does not clear it.
- R10: A word accepted before the previous one has been fully read replaces the latched word.
- R11: `busOe` is high exactly while `readN` is low. While `busOe` is low, `busOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowRate | input | 1 | 0: tick = clk/10, 1: tick = clk/80 |
| railHi | input | 1 | Ones rail |
| railLo | input | 1 | Zeros rail |
| matchEn | input | 1 | Enables the filter on bits 9 and 10 |
| matchBits | input | 2 | Required values: [0] for bit 9, [1] for bit 10 |
| halfSel | input | 1 | Selects which 16-bit half is read |
| readN | input | 1 | Active-low read strobe |
| busOut | output | 16 | Selected half of the latched word |
| busOe | output | 1 | Output enable for the external tri-state driver |
| readyN | output | 1 | Active-low word-ready flag |

## Verification
The assertions assume that the rails change only at whole sample-tick boundaries. They also assume that `slowRate` and the match settings stay constant while a word is on the line, and that a read strobe lasts at least one clock with `halfSel` steady. The bench drives every rail level for an exact multiple of the divider, always on the falling clock edge. It changes the rate and the filter settings only during word gaps. Each read strobe lasts exactly one clock.

// File: rtl/a429RxPkg.sv
package a429RxPkg;
  localparam int WORD_BITS = 32;
  localparam int HALF_BITS = WORD_BITS / 2;

  typedef enum logic [1:0] {
    LV_NULL = 2'd0,
    LV_ONE  = 2'd1,
    LV_ZERO = 2'd2
  } level_e;

  typedef enum logic {
    ST_WAIT_GAP = 1'b0,
    ST_RUN      = 1'b1
  } seqState_e;

  typedef struct packed {
    logic shift;
    logic bitVal;
    logic eos;
  } rxStrobe_t;
endpackage

// File: rtl/a429RxCtrl.sv
module a429RxCtrl
  import a429RxPkg::*;
#(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_DIV    = 80,
  parameter int MIN_RUN     = 3,
  parameter int MAX_RUN     = 7,
  parameter int GAP_SAMPLES = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      slowRate,
  input  logic      railHi,
  input  logic      railLo,
  output rxStrobe_t strobe
);
  localparam int DIV_W = $clog2(SLOW_DIV);
  localparam int RUN_W = $clog2(MAX_RUN + 2);
  localparam int NUL_W = $clog2(GAP_SAMPLES + 1);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(MAX_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MIN  = RUN_W'(MIN_RUN);
  localparam logic [NUL_W-1:0] GAP_LIM  = NUL_W'(GAP_SAMPLES);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  logic [1:0]       hiSync, loSync;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  level_e           level, curLvl;
  seqState_e        state;
  logic [RUN_W-1:0] runLen, runNext;
  logic [NUL_W-1:0] nullLen, nullNext;
  logic [CNT_W-1:0] bitCount;
  logic             bothHigh;

  // two-stage synchroniser per rail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSync <= '0;
      loSync <= '0;
    end else begin
      hiSync <= {hiSync[0], railHi};
      loSync <= {loSync[0], railLo};
    end
  end

  // sample tick divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign tick = (divCnt == (slowRate ? SLOW_LIM : FAST_LIM));

  always_comb begin
    bothHigh = hiSync[1] & loSync[1];
    if (hiSync[1])      curLvl = LV_ONE;
    else if (loSync[1]) curLvl = LV_ZERO;
    else                curLvl = LV_NULL;
    runNext  = (runLen == RUN_SAT) ? runLen : runLen + 1'b1;
    nullNext = (nullLen == GAP_LIM) ? nullLen : nullLen + 1'b1;
  end

  // sequence control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT_GAP;
      level    <= LV_NULL;
      runLen   <= '0;
      nullLen  <= '0;
      bitCount <= '0;
      strobe   <= '0;
    end else begin
      strobe <= '0;
      if (tick) begin
        if (bothHigh) begin
          state    <= ST_WAIT_GAP;
          bitCount <= '0;
          level    <= LV_NULL;
          runLen   <= '0;
          nullLen  <= '0;
        end else if (curLvl == LV_NULL) begin
          nullLen <= nullNext;
          level   <= LV_NULL;
          runLen  <= '0;
          if (level != LV_NULL && state == ST_RUN) begin
            if (runLen >= RUN_MIN && runLen <= RUN_W'(MAX_RUN)) begin
              strobe.shift  <= 1'b1;
              strobe.bitVal <= (level == LV_ONE);
              if (bitCount == LAST_BIT) begin
                strobe.eos <= 1'b1;
                bitCount   <= '0;
                state      <= ST_WAIT_GAP;
              end else begin
                bitCount <= bitCount + 1'b1;
              end
            end else begin
              state    <= ST_WAIT_GAP;
              bitCount <= '0;
            end
          end else if (nullNext == GAP_LIM) begin
            state    <= ST_RUN;
            bitCount <= '0;
          end
        end else begin
          nullLen <= '0;
          if (level == LV_NULL) begin
            level  <= curLvl;
            runLen <= RUN_W'(1);
          end else if (level == curLvl) begin
            runLen <= runNext;
            if (runNext > RUN_W'(MAX_RUN)) begin
              state    <= ST_WAIT_GAP;
              bitCount <= '0;
            end
          end else begin
            level    <= curLvl;
            runLen   <= RUN_W'(1);
            state    <= ST_WAIT_GAP;
            bitCount <= '0;
          end
        end
      end
    end
  end

  // recovered bits are at least one full tick apart
  assert_bit_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> !strobe.shift);

  // a bit is only shifted out of a run that has just returned to null
  assert_bit_after_null_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> (level == LV_NULL));
endmodule

// File: rtl/a429RxData.sv
module a429RxData
  import a429RxPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 matchEn,
  input  logic [1:0]           matchBits,
  input  logic                 halfSel,
  input  logic                 readN,
  output logic [HALF_BITS-1:0] busOut,
  output logic                 busOe,
  output logic                 readyN
);
  logic [WORD_BITS-1:0] shiftReg, shiftNext, word;
  logic                 accept;
  logic [1:0]           readMask, hitMask;
  logic [HALF_BITS-1:0] halfLow, halfHigh;

  always_comb begin
    shiftNext = {strobe.bitVal, shiftReg[WORD_BITS-1:1]};
    accept    = strobe.eos &&
                (!matchEn || (shiftNext[8] == matchBits[0] && shiftNext[9] == matchBits[1]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      word     <= '0;
    end else begin
      if (strobe.shift) shiftReg <= shiftNext;
      if (accept)       word     <= {~(^shiftNext), shiftNext[WORD_BITS-2:0]};
    end
  end

  // ready flag and half tracking
  always_comb begin
    hitMask = readMask;
    if (!readN && !readyN) hitMask[halfSel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyN   <= 1'b1;
      readMask <= '0;
    end else if (accept) begin
      readyN   <= 1'b0;
      readMask <= '0;
    end else if (hitMask == 2'b11) begin
      readyN   <= 1'b1;
      readMask <= '0;
    end else begin
      readMask <= hitMask;
    end
  end

  // readout mapping
  assign halfLow[15:11] = word[12:8];
  assign halfLow[10]    = word[30];
  assign halfLow[9]     = word[29];
  assign halfLow[8]     = word[31];
  generate
    for (genvar i = 0; i < 8; i++) begin : g_lowByte
      assign halfLow[7-i] = word[i];
    end
  endgenerate
  assign halfHigh = word[28:13];

  assign busOe  = !readN;
  assign busOut = busOe ? (halfSel ? halfHigh : halfLow) : '0;

  assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> $past(strobe.eos));

  assert_ready_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyN) |-> $past(!readN));

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.eos |=> $stable(word));

  assert_bus_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    readN |-> (busOut == '0));
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429RxPkg::*;
#(
  parameter int FAST_DIV        = 10,
  parameter int SLOW_DIV        = 80,
  parameter int SAMPLES_PER_BIT = 10,
  parameter int MIN_RUN         = 3,
  parameter int MAX_RUN         = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowRate,
  input  logic        railHi,
  input  logic        railLo,
  input  logic        matchEn,
  input  logic [1:0]  matchBits,
  input  logic        halfSel,
  input  logic        readN,
  output logic [15:0] busOut,
  output logic        busOe,
  output logic        readyN
);
  localparam int GAP_SAMPLES = 3 * SAMPLES_PER_BIT - SAMPLES_PER_BIT / 2;

  rxStrobe_t strobe;

  a429RxCtrl #(
    .FAST_DIV   (FAST_DIV),
    .SLOW_DIV   (SLOW_DIV),
    .MIN_RUN    (MIN_RUN),
    .MAX_RUN    (MAX_RUN),
    .GAP_SAMPLES(GAP_SAMPLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slowRate(slowRate),
    .railHi  (railHi),
    .railLo  (railLo),
    .strobe  (strobe)
  );

  a429RxData i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .matchEn  (matchEn),
    .matchBits(matchBits),
    .halfSel  (halfSel),
    .readN    (readN),
    .busOut   (busOut),
    .busOe    (busOe),
    .readyN   (readyN)
  );
endmodule

// File: tb/test_a429_word_rx.sv
module test_a429_word_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowRate = 1'b0;
  logic        railHi = 1'b0;
  logic        railLo = 1'b0;
  logic        matchEn = 1'b0;
  logic [1:0]  matchBits = 2'b00;
  logic        halfSel = 1'b0;
  logic        readN = 1'b1;
  logic [15:0] busOut;
  logic        busOe;
  logic        readyN;

  int checks = 0;
  int failures = 0;
  int div = 10;
  logic [31:0] latched = '0;

  a429_word_rx i_a429_word_rx (
    .clk(clk), .rstN(rstN), .slowRate(slowRate), .railHi(railHi), .railLo(railLo),
    .matchEn(matchEn), .matchBits(matchBits), .halfSel(halfSel), .readN(readN),
    .busOut(busOut), .busOe(busOe), .readyN(readyN)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] expLow(input logic [31:0] w);
    logic p;
    p = ~(^w);
    return {w[12:8], w[30], w[29], p, w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
  endfunction

  function automatic logic [15:0] expHigh(input logic [31:0] w);
    return w[28:13];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic hi, input logic lo, input int samples);
    railHi = hi;
    railLo = lo;
    repeat (samples * div) @(negedge clk);
  endtask

  // kind: 0 normal, 1 both rails high, 2 direct rail swap, 3 short run, 4 long run
  task automatic sendBit(input logic v, input int kind);
    case (kind)
      1: begin hold(1, 1, 5); hold(0, 0, 5); end
      2: begin hold(v, !v, 5); hold(!v, v, 5); hold(0, 0, 1); end
      3: begin hold(v, !v, 2); hold(0, 0, 8); end
      4: begin hold(v, !v, 9); hold(0, 0, 5); end
      default: begin hold(v, !v, 5); hold(0, 0, 5); end
    endcase
  endtask

  task automatic sendWord(input logic [31:0] w, input int nbits, input int kind, input int badIdx);
    for (int i = 0; i < nbits; i++) sendBit(w[i], (i == badIdx) ? kind : 0);
    hold(0, 0, 40);
  endtask

  task automatic readHalf(input logic sel, output logic [15:0] v);
    @(negedge clk);
    halfSel = sel;
    readN = 1'b0;
    #2;
    v = busOut;
    check("R11 oe during read", {31'd0, busOe}, 32'd1);
    @(negedge clk);
    readN = 1'b1;
    #2;
    check("R11 bus idle", {15'd0, busOe, busOut}, 32'd0);
  endtask

  task automatic readBoth(input logic [31:0] w, input logic highFirst, input string tag);
    logic [15:0] v;
    readHalf(highFirst, v);
    check({tag, " first half"}, {16'd0, v}, {16'd0, highFirst ? expHigh(w) : expLow(w)});
    @(negedge clk);
    @(negedge clk);
    check("R9 flag held after one half", {31'd0, readyN}, 32'd0);
    readHalf(!highFirst, v);
    check({tag, " second half"}, {16'd0, v}, {16'd0, highFirst ? expLow(w) : expHigh(w)});
    @(negedge clk);
    @(negedge clk);
    check("R9 flag cleared after both halves", {31'd0, readyN}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    logic        acc;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    #2;
    check("R9 reset flag", {31'd0, readyN}, 32'd1);
    check("R11 reset bus", {15'd0, busOe, busOut}, 32'd0);
    rstN = 1'b1;
    hold(0, 0, 40);

    // R6 all zeros: even count, parity result 1; R7/R8 read high half first
    sendWord(32'h0000_0000, 32, 0, -1);
    check("R2 word accepted", {31'd0, readyN}, 32'd0);
    latched = 32'h0000_0000;
    readBoth(latched, 1'b1, "R6 R8 R7 zero word");

    // R10 overwrite: two words without reading, odd parity on the first
    sendWord(32'h0000_0001, 32, 0, -1);
    sendWord(32'h1234_5678, 32, 0, -1);
    latched = 32'h1234_5678;
    readBoth(latched, 1'b0, "R10 overwrite R7");

    // R9 reading the same half twice does not clear the flag
    sendWord(32'h8000_0001, 32, 0, -1);
    latched = 32'h8000_0001;
    readHalf(1'b0, v);
    readHalf(1'b0, v);
    @(negedge clk);
    check("R9 same half twice", {31'd0, readyN}, 32'd0);
    readHalf(1'b1, v);
    check("R8 high half", {16'd0, v}, {16'd0, expHigh(latched)});
    @(negedge clk);
    @(negedge clk);
    check("R9 cleared", {31'd0, readyN}, 32'd1);

    // R5 mismatch drops the word, match accepts
    matchEn = 1'b1;
    matchBits = 2'b11;
    sendWord(32'hFFFF_FCFF, 32, 0, -1);
    check("R5 mismatch flag", {31'd0, readyN}, 32'd1);
    readHalf(1'b0, v);
    check("R5 mismatch latch kept", {16'd0, v}, {16'd0, expLow(latched)});
    sendWord(32'h0000_0300, 32, 0, -1);
    check("R5 match flag", {31'd0, readyN}, 32'd0);
    latched = 32'h0000_0300;
    readBoth(latched, 1'b0, "R5 matched word");
    matchEn = 1'b0;

    // R3 error cases, each word must be dropped
    for (int k = 1; k <= 4; k++) begin
      sendWord(32'hA5A5_5A5A, 32, k, 11);
      check("R3 errored word dropped", {31'd0, readyN}, 32'd1);
      readHalf(1'b1, v);
      check("R3 latch kept", {16'd0, v}, {16'd0, expHigh(latched)});
    end

    // R4 partial word then gap, next full word stands alone
    sendWord(32'hFFFF_FFFF, 10, 0, -1);
    sendWord(32'h0F0F_1234, 32, 0, -1);
    latched = 32'h0F0F_1234;
    check("R4 word after gap", {31'd0, readyN}, 32'd0);
    readBoth(latched, 1'b1, "R4 partial discarded");

    // R1 low rate
    slowRate = 1'b1;
    div = 80;
    hold(0, 0, 5);
    sendWord(32'h7654_3210, 32, 0, -1);
    latched = 32'h7654_3210;
    check("R1 slow word", {31'd0, readyN}, 32'd0);
    readBoth(latched, 1'b0, "R1 slow");
    slowRate = 1'b0;
    div = 10;
    hold(0, 0, 40);

    // random words with random filter settings
    for (int n = 0; n < 8; n++) begin
      w = $urandom;
      matchEn = 1'($urandom);
      matchBits = 2'($urandom);
      acc = !matchEn || (w[9:8] == {matchBits[1], matchBits[0]});
      sendWord(w, 32, 0, -1);
      check("R5 random accept", {31'd0, readyN}, {31'd0, !acc});
      if (acc) begin
        latched = w;
        readBoth(latched, 1'($urandom), "R6 R7 R8 random");
      end else begin
        readHalf(1'b0, v);
        check("R5 random drop keeps latch", {16'd0, v}, {16'd0, expLow(latched)});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule